// File: doc/BRIEF.md
# External Data Memory Cycle Stretch Sequencer

This block turns a single-cycle memory request from a CPU core into a timed external data memory access. A 3-bit stretch setting (0 to 7) sets how many clocks each access lasts. Reads and writes follow different timing rules. The block drives the address, the write data, an address-valid qualifier and separate read and write strobes. For a read it captures the returned data. Every access ends with a one-clock done pulse.

While an access is running, a busy output stalls the core, and any request presented during that time is dropped. The stretch register can be written at any time. A new value is only picked up when the next access starts, so an access already in flight keeps the timing it began with.

Top module: `xmem_stretch_seq`

## Requirements
- R1: After reset the stretch register reads 1 on `cfg_stretch_o`. At the same time `busy_o`, `done_o`, `mem_addr_vld_o`, `mem_rd_o` and `mem_wr_o` are all low. Asserting `cfg_we_i` loads `cfg_wdata_i` into the register at the next clock edge.
- R2: A read accepted at a clock edge holds `mem_addr_vld_o` and `mem_rd_o` high for exactly stretch+1 consecutive clocks. This window begins on the clock right after acceptance.
- R3: A write accepted at a clock edge holds `mem_addr_vld_o` high for exactly stretch+2 consecutive clocks, beginning on the clock right after acceptance. That is 2 clocks at stretch 0 and 9 clocks at stretch 7.
- R4: The write strobe `mem_wr_o` is high for 1 clock at stretch 0 or 1. For stretch 2 to 7 it is high for a number of clocks equal to the stretch value.
- R5: The write strobe is one contiguous pulse that starts on the second clock of the address-valid window. It is never high on the window's first clock.
- R6: Read data is sampled from `mem_rdata_i` on the last clock of the read strobe and held on `rdata_o`. For both reads and writes, `done_o` is high for exactly one clock, on the clock after the address-valid window ends.
- R7: `busy_o` is high on exactly the clocks of the address-valid window. A request (`req_i` high) is accepted only on a clock where `busy_o` is low.
- R8: A request raised while `busy_o` is high is ignored. It starts no further access, and it leaves the address and data of the running access unchanged.
- R9: The stretch value used by an access is the register value at acceptance. A write to the register during an access, or on the acceptance clock itself, takes effect only at the next accepted access.
- R10: `mem_rd_o` and `mem_wr_o` are never high together. `mem_addr_o` holds the request address for the whole window. `mem_wdata_o` holds the request write data for the whole window of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Stretch register write enable |
| cfg_wdata_i | input | SW (3) | New stretch value |
| cfg_stretch_o | output | SW (3) | Current stretch register value |
| req_i | input | 1 | Access request, one clock |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW (16) | Access address |
| req_wdata_i | input | DW (8) | Write data |
| busy_o | output | 1 | Access in progress; core must stall |
| done_o | output | 1 | One-clock end-of-access pulse |
| rdata_o | output | DW (8) | Captured read data |
| mem_addr_o | output | AW (16) | Memory address, zero when idle |
| mem_addr_vld_o | output | 1 | Address-valid window |
| mem_wdata_o | output | DW (8) | Memory write data |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_rdata_i | input | DW (8) | Memory read data |

## Verification
A wrong cycle count or a wrong latched stretch value changes the length of the address-valid window or of a strobe. That error shows at the ports within the same access, at most nine clocks after acceptance.

The bench changes the memory read data on every strobe clock. As a result, sampling one clock early or late returns the wrong word on `rdata_o` at the done pulse. A lost busy condition lets an ignored request start a second window, which shows up as extra address-valid clocks right after done.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int unsigned STRETCH_W = 3;

  typedef enum logic {
    OP_RD = 1'b0,
    OP_WR = 1'b1
  } op_e;

  // write strobe width: 1 for stretch 0/1, else the stretch value
  function automatic int unsigned wr_strobe_len(input int unsigned s);
    return (s < 2) ? 1 : s;
  endfunction
endpackage

// File: rtl/xmem_stretch_reg.sv
module xmem_stretch_reg #(
  parameter int unsigned SW        = 3,
  parameter int unsigned RESET_VAL = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [SW-1:0] wdata_i,
  output logic [SW-1:0] stretch_o
);
  logic [SW-1:0] stretch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   stretch_q <= SW'(RESET_VAL);
    else if (we_i) stretch_q <= wdata_i;
  end

  assign stretch_o = stretch_q;
endmodule

// File: rtl/xmem_cycle_timer.sv
module xmem_cycle_timer
  import xmem_pkg::*;
#(
  parameter int unsigned SW = 3,
  localparam int unsigned CW = $clog2((1 << SW) + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  op_e           start_op_i,
  input  logic [SW-1:0] stretch_i,
  output logic          active_o,
  output op_e           op_o,
  output logic [SW-1:0] stretch_o,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  logic          active_q;
  op_e           op_q;
  logic [SW-1:0] stretch_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_idx;

  // read window spans stretch+1 clocks, write window one more
  assign last_idx = CW'(stretch_q) + ((op_q == OP_WR) ? CW'(1) : CW'(0));
  assign last_o   = active_q && (cnt_q == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      op_q      <= OP_RD;
      stretch_q <= '0;
      cnt_q     <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q  <= 1'b1;
        op_q      <= start_op_i;
        stretch_q <= stretch_i;
        cnt_q     <= '0;
      end
    end else if (last_o) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign active_o  = active_q;
  assign op_o      = op_q;
  assign stretch_o = stretch_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/xmem_strobe_shaper.sv
module xmem_strobe_shaper
  import xmem_pkg::*;
#(
  parameter int unsigned SW = 3,
  localparam int unsigned CW = $clog2((1 << SW) + 2)
) (
  input  logic          active_i,
  input  op_e           op_i,
  input  logic [SW-1:0] stretch_i,
  input  logic [CW-1:0] cnt_i,
  output logic          addr_vld_o,
  output logic          rd_o,
  output logic          wr_o
);
  logic [CW-1:0] wr_len;

  assign wr_len     = CW'(wr_strobe_len(int'(stretch_i)));
  assign addr_vld_o = active_i;
  assign rd_o       = active_i && (op_i == OP_RD);
  // strobe skips clock 0 of the window to give one clock of address setup
  assign wr_o       = active_i && (op_i == OP_WR) && (cnt_i != '0) && (cnt_i <= wr_len);
endmodule

// File: rtl/xmem_stretch_seq.sv
module xmem_stretch_seq
  import xmem_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter int unsigned SW = STRETCH_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [SW-1:0] cfg_wdata_i,
  output logic [SW-1:0] cfg_stretch_o,
  input  logic          req_i,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_addr_vld_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int unsigned CW = $clog2((1 << SW) + 2);

  logic          active;
  logic          last;
  logic          start;
  op_e           op;
  op_e           req_op;
  logic [SW-1:0] cur_stretch;
  logic [CW-1:0] cnt;
  logic          rd_s;
  logic          wr_s;
  logic          vld_s;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          done_q;

  assign start  = req_i && !active;
  assign req_op = req_we_i ? OP_WR : OP_RD;

  xmem_stretch_reg #(.SW(SW), .RESET_VAL(1)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .stretch_o (cfg_stretch_o)
  );

  xmem_cycle_timer #(.SW(SW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .start_op_i (req_op),
    .stretch_i  (cfg_stretch_o),
    .active_o   (active),
    .op_o       (op),
    .stretch_o  (cur_stretch),
    .cnt_o      (cnt),
    .last_o     (last)
  );

  xmem_strobe_shaper #(.SW(SW)) u_shaper (
    .active_i   (active),
    .op_i       (op),
    .stretch_i  (cur_stretch),
    .cnt_i      (cnt),
    .addr_vld_o (vld_s),
    .rd_o       (rd_s),
    .wr_o       (wr_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (start) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (rd_s && last) rdata_q <= mem_rdata_i;
      done_q <= last;
    end
  end

  assign busy_o         = active;
  assign done_o         = done_q;
  assign rdata_o        = rdata_q;
  assign mem_addr_o     = active ? addr_q : '0;
  assign mem_addr_vld_o = vld_s;
  assign mem_wdata_o    = (active && op == OP_WR) ? wdata_q : '0;
  assign mem_rd_o       = rd_s;
  assign mem_wr_o       = wr_s;
endmodule

// File: rtl/xmem_stretch_seq_chk.sv
module xmem_stretch_seq_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter int unsigned SW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic [SW-1:0] cfg_wdata_i,
  input logic [SW-1:0] cfg_stretch_o,
  input logic          req_i,
  input logic          req_we_i,
  input logic [AW-1:0] req_addr_i,
  input logic [DW-1:0] req_wdata_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [DW-1:0] rdata_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_addr_vld_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic [DW-1:0] mem_rdata_i
);
  p_rd_in_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> mem_addr_vld_o);

  p_wr_not_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_addr_vld_o) |-> !mem_wr_o);

  p_done_after_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_addr_vld_o) |-> done_o);

  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == mem_addr_vld_o);

  p_addr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(mem_addr_o));

  p_no_overlap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
endmodule

bind xmem_stretch_seq xmem_stretch_seq_chk #(.AW(AW), .DW(DW), .SW(SW)) u_chk (.*);

// File: tb/xmem_stretch_seq_test.sv
module xmem_stretch_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int SW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [SW-1:0] cfg_wdata_i = '0;
  logic [SW-1:0] cfg_stretch_o;
  logic          req_i = 1'b0;
  logic          req_we_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic          busy_o, done_o;
  logic [DW-1:0] rdata_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_addr_vld_o;
  logic [DW-1:0] mem_wdata_o;
  logic          mem_rd_o, mem_wr_o;
  logic [DW-1:0] mem_rdata_i = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xmem_stretch_seq #(.AW(AW), .DW(DW), .SW(SW)) uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic set_stretch(input int v);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = SW'(v);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    chk(cfg_stretch_o == SW'(v), "R1 stretch write", int'(cfg_stretch_o), v);
  endtask

  // one access; s = stretch expected to govern it
  task automatic access(input bit we, input int addr, input int wd, input int s,
                        input bit inj_req, input bit inj_cfg, input int cfg_val,
                        input bit cfg_same);
    int av_n = 0, rd_n = 0, wr_n = 0, busy_n = 0;
    int wr_first = -1, wr_last = -1, done_k = -1;
    bit addr_ok = 1, wd_ok = 1, mix = 0;
    logic [DW-1:0] base = DW'(addr) ^ 8'h3c;
    int exp_av = we ? s + 2 : s + 1;
    int exp_wr = (s < 2) ? 1 : s;
    @(negedge clk_i);
    req_i = 1'b1; req_we_i = we; req_addr_i = AW'(addr); req_wdata_i = DW'(wd);
    if (cfg_same) begin cfg_we_i = 1'b1; cfg_wdata_i = SW'(cfg_val); end
    @(negedge clk_i);
    req_i = 1'b0; cfg_we_i = 1'b0;
    for (int k = 0; k < 14; k++) begin
      if (mem_addr_vld_o) begin
        av_n++;
        if (mem_addr_o != AW'(addr)) addr_ok = 0;
        if (we && mem_wdata_o != DW'(wd)) wd_ok = 0;
      end
      if (busy_o) busy_n++;
      if (mem_rd_o) begin mem_rdata_i = base + DW'(rd_n); rd_n++; end
      if (mem_wr_o) begin
        if (wr_first < 0) wr_first = k;
        wr_last = k; wr_n++;
      end
      if (mem_rd_o && mem_wr_o) mix = 1;
      if (done_o && done_k < 0) done_k = k;
      if (inj_req && k == 1) begin
        req_i = 1'b1; req_we_i = ~we; req_addr_i = AW'(addr ^ 16'h5555);
      end else req_i = 1'b0;
      if (inj_cfg && k == 0) begin cfg_we_i = 1'b1; cfg_wdata_i = SW'(cfg_val); end
      else cfg_we_i = 1'b0;
      @(negedge clk_i);
    end
    if (we) begin
      chk(av_n == exp_av, "R3 write addr-valid clocks", av_n, exp_av);
      chk(wr_n == exp_wr, "R4 write strobe clocks", wr_n, exp_wr);
      chk(wr_first == 1, "R5 write strobe start", wr_first, 1);
      chk(wr_last - wr_first + 1 == wr_n, "R5 write strobe contiguous", wr_last - wr_first + 1, wr_n);
      chk(rd_n == 0, "R10 no read strobe on write", rd_n, 0);
      chk(wd_ok, "R10 write data held", int'(wd_ok), 1);
    end else begin
      chk(av_n == exp_av, "R2 read addr-valid clocks", av_n, exp_av);
      chk(rd_n == exp_av, "R2 read strobe clocks", rd_n, exp_av);
      chk(wr_n == 0, "R10 no write strobe on read", wr_n, 0);
      chk(rdata_o == base + DW'(s), "R6 read data from last strobe clock", int'(rdata_o), int'(base + DW'(s)));
    end
    chk(done_k == exp_av, "R6 done clock", done_k, exp_av);
    chk(busy_n == exp_av, "R7 busy clocks", busy_n, exp_av);
    chk(addr_ok, "R10 address held", int'(addr_ok), 1);
    chk(!mix, "R10 strobes exclusive", int'(mix), 0);
    if (inj_req) chk(av_n == exp_av, "R8 request while busy ignored", av_n, exp_av);
  endtask

  task automatic t_reset;
    chk(cfg_stretch_o == 3'd1, "R1 reset stretch", int'(cfg_stretch_o), 1);
    chk(!busy_o && !done_o, "R1 reset busy/done", int'({busy_o, done_o}), 0);
    chk(!mem_addr_vld_o && !mem_rd_o && !mem_wr_o, "R1 reset strobes",
        int'({mem_addr_vld_o, mem_rd_o, mem_wr_o}), 0);
  endtask

  task automatic t_sweep;
    for (int s = 0; s < 8; s++) begin
      set_stretch(s);
      access(1'b0, 16'h1200 + s, 0, s, 0, 0, 0, 0);
      access(1'b1, 16'h3400 + s, 8'h90 + s, s, 0, 0, 0, 0);
    end
  endtask

  task automatic t_ignore;
    set_stretch(4);
    access(1'b0, 16'hbeef, 0, 4, 1, 0, 0, 0);
    access(1'b1, 16'hcafe, 8'h5a, 4, 1, 0, 0, 0);
  endtask

  task automatic t_midchange;
    set_stretch(2);
    // R9: write during access, current uses 2, next uses 6
    access(1'b1, 16'h0100, 8'h11, 2, 0, 1, 6, 0);
    chk(cfg_stretch_o == 3'd6, "R9 register updated", int'(cfg_stretch_o), 6);
    access(1'b0, 16'h0200, 0, 6, 0, 0, 0, 0);
    // R9: write on acceptance clock, current still uses 6
    access(1'b0, 16'h0300, 0, 6, 0, 0, 0, 1);
    access(1'b1, 16'h0400, 8'h22, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL R7 watchdog act=timeout exp=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_sweep;
    t_ignore;
    t_midchange;
    repeat (2) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule